// File: doc/BRIEF.md
# Staggered Converter-Section Phase Sequencer

This block takes one free-running clock and derives the control strobes for a bank of parallel successive-approximation converter sections. Each section runs the same repeating frame. The frame opens with three calibration steps: a reference-zero capture, an offset-nulling comparison and a gain-trim comparison. An input-capture step follows, then a run of successive-approximation cycles, and the frame closes with one result-handoff step. The number of approximation cycles sets the frame length, and the bank holds one section per frame cycle.

Each section's frame lags the frame of the section below it by one clock. As a result exactly one section captures the input on every clock, and exactly one hands its result off on every clock. For each section the block drives six one-hot step strobes. It also reports the index of the section that is capturing now and the index of the section that is handing off now, so a downstream output multiplexer can pick the right result. At default parameters there are 11 approximation cycles, a 16-cycle frame and 16 sections.

Top module: `stagger_seq`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), all state is set so that section 0 is at frame cycle 1 (reference-zero step). Each section k is at frame cycle 1+((16−k) mod 16): section 1 is at the handoff step and section 13 is at the input-capture step.
- R2: Within a frame, cycle 1 asserts `zref_stb`, cycle 2 asserts `azero_stb`, cycle 3 asserts `acal_stb` and cycle 4 asserts `samp_stb`, each on the section's own bit (bit k belongs to section k).
- R3: Cycles 5 to 15 (SAR_CYC = 11 cycles) assert `sar_stb`, cycle 16 asserts `xfer_stb`, and the following cycle starts the frame again at cycle 1, so every section repeats with a period of 16 clocks.
- R4: Section k shows at each clock the strobes that section k−1 (mod 16) showed one clock earlier, whenever no reset intervenes.
- R5: On every clock, exactly one bit of `samp_stb` and exactly one bit of `xfer_stb` are high.
- R6: `samp_idx` equals the index of the single section whose `samp_stb` bit is high.
- R7: `xfer_idx` equals the index of the single section whose `xfer_stb` bit is high, and it always equals `samp_idx` − 12 mod 16.
- R8: Each section asserts exactly one of its six step strobes on every clock.
- R9: A reset applied in the middle of a run returns every output to the R1 state, and the pattern resumes from that state on the first clock after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| zref_stb | output | NSECT | Per-section reference-zero capture strobe |
| azero_stb | output | NSECT | Per-section offset-nulling comparison strobe |
| acal_stb | output | NSECT | Per-section gain-trim comparison strobe |
| samp_stb | output | NSECT | Per-section input-capture strobe |
| sar_stb | output | NSECT | Per-section approximation-active strobe |
| xfer_stb | output | NSECT | Per-section result-handoff strobe |
| samp_idx | output | IDX_W | Index of the section capturing this clock |
| xfer_idx | output | IDX_W | Index of the section handing off this clock |

## Verification
The bench builds the block with its default SAR_CYC of 11. That gives a 16-cycle frame, 16 sections and 4-bit indices, so the wrap of every section's frame counter and both index counters is exercised many times over. Random reset pulses land at arbitrary frame positions, which tests mid-run restart from every offset of the pattern. Because the frame length equals a power of two, the index subtraction modulo 16 also falls within reach of the checks at its natural wrap.

// File: rtl/stagger_pkg.sv
`timescale 1ns/1ps
package stagger_pkg;

    // Fixed calibration/capture steps that open every frame
    localparam int unsigned LEAD_STEPS = 4;
    // Zero-based frame position of the input-capture step
    localparam int unsigned CAPTURE_POS = 3;

    typedef enum logic [2:0] {
        STEP_ZREF,
        STEP_AZERO,
        STEP_ACAL,
        STEP_CAPTURE,
        STEP_APPROX,
        STEP_HANDOFF
    } step_e;

    typedef struct packed {
        logic zref;
        logic azero;
        logic acal;
        logic capture;
        logic approx;
        logic handoff;
    } strobe_t;

    // Map a zero-based frame position to its step
    function automatic step_e step_at(input int unsigned pos, input int unsigned sar_len);
        step_e s;
        if (pos == 0)                          s = STEP_ZREF;
        else if (pos == 1)                     s = STEP_AZERO;
        else if (pos == 2)                     s = STEP_ACAL;
        else if (pos == CAPTURE_POS)           s = STEP_CAPTURE;
        else if (pos < LEAD_STEPS + sar_len)   s = STEP_APPROX;
        else                                   s = STEP_HANDOFF;
        return s;
    endfunction

    function automatic strobe_t strobes_for(input step_e s);
        strobe_t o;
        o = '0;
        case (s)
            STEP_ZREF:    o.zref    = 1'b1;
            STEP_AZERO:   o.azero   = 1'b1;
            STEP_ACAL:    o.acal    = 1'b1;
            STEP_CAPTURE: o.capture = 1'b1;
            STEP_APPROX:  o.approx  = 1'b1;
            default:      o.handoff = 1'b1;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/section_frame.sv
`timescale 1ns/1ps
module section_frame
    import stagger_pkg::*;
#(
    parameter int unsigned SAR_CYC   = 11,
    parameter int unsigned FRAME_LEN = SAR_CYC + LEAD_STEPS + 1,
    parameter int unsigned POS_W     = $clog2(FRAME_LEN),
    parameter int unsigned SECT_ID   = 0
) (
    input  logic    clk,
    input  logic    rst,
    output strobe_t stb
);
    localparam int unsigned    RST_POS_I = (FRAME_LEN - (SECT_ID % FRAME_LEN)) % FRAME_LEN;
    localparam logic [POS_W-1:0] RST_POS = POS_W'(RST_POS_I);
    localparam logic [POS_W-1:0] LAST    = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)               pos_q <= RST_POS;
        else if (pos_q == LAST) pos_q <= '0;
        else                   pos_q <= pos_q + 1'b1;
    end

    always_comb stb = strobes_for(step_at(int'(pos_q), SAR_CYC));

    AST_ZREF_THEN_AZERO: assert property (@(posedge clk) disable iff (rst)
        stb.zref |=> stb.azero) else $error("zref not followed by azero"); // R2
    AST_AZERO_THEN_ACAL: assert property (@(posedge clk) disable iff (rst)
        stb.azero |=> stb.acal) else $error("azero not followed by acal"); // R2
    AST_ACAL_THEN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        stb.acal |=> stb.capture) else $error("acal not followed by capture"); // R2
    AST_CAPTURE_THEN_APPROX: assert property (@(posedge clk) disable iff (rst)
        stb.capture |=> stb.approx) else $error("capture not followed by approx"); // R3
    AST_HANDOFF_THEN_ZREF: assert property (@(posedge clk) disable iff (rst)
        stb.handoff |=> stb.zref) else $error("handoff not followed by zref"); // R3
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(stb) == 1) else $error("section step strobes not one-hot"); // R8

endmodule

// File: rtl/slot_tracker.sv
`timescale 1ns/1ps
module slot_tracker
    import stagger_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 16,
    parameter int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] cap_idx,
    output logic [IDX_W-1:0] hand_idx
);
    // Section at capture after reset is the one whose offset lands on CAPTURE_POS
    localparam logic [IDX_W-1:0] CAP_RST  = IDX_W'((FRAME_LEN - CAPTURE_POS) % FRAME_LEN);
    // Section at handoff after reset sits on the last frame position
    localparam logic [IDX_W-1:0] HAND_RST = IDX_W'(1 % FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST     = IDX_W'(FRAME_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_idx  <= CAP_RST;
            hand_idx <= HAND_RST;
        end else begin
            cap_idx  <= (cap_idx  == LAST) ? '0 : cap_idx  + 1'b1;
            hand_idx <= (hand_idx == LAST) ? '0 : hand_idx + 1'b1;
        end
    end

endmodule

// File: rtl/stagger_seq.sv
`timescale 1ns/1ps
module stagger_seq
    import stagger_pkg::*;
#(
    parameter  int unsigned SAR_CYC = 11,
    localparam int unsigned NSECT   = SAR_CYC + LEAD_STEPS + 1,
    localparam int unsigned IDX_W   = $clog2(NSECT)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [NSECT-1:0] zref_stb,
    output logic [NSECT-1:0] azero_stb,
    output logic [NSECT-1:0] acal_stb,
    output logic [NSECT-1:0] samp_stb,
    output logic [NSECT-1:0] sar_stb,
    output logic [NSECT-1:0] xfer_stb,
    output logic [IDX_W-1:0] samp_idx,
    output logic [IDX_W-1:0] xfer_idx
);
    localparam logic [IDX_W-1:0] IDX_GAP = IDX_W'(NSECT - 1 - CAPTURE_POS);

    strobe_t sect_stb [NSECT];

    for (genvar k = 0; k < NSECT; k++) begin : g_sect
        section_frame #(
            .SAR_CYC  (SAR_CYC),
            .FRAME_LEN(NSECT),
            .POS_W    (IDX_W),
            .SECT_ID  (k)
        ) u_sect (
            .clk(clk),
            .rst(rst),
            .stb(sect_stb[k])
        );
        assign zref_stb[k]  = sect_stb[k].zref;
        assign azero_stb[k] = sect_stb[k].azero;
        assign acal_stb[k]  = sect_stb[k].acal;
        assign samp_stb[k]  = sect_stb[k].capture;
        assign sar_stb[k]   = sect_stb[k].approx;
        assign xfer_stb[k]  = sect_stb[k].handoff;
    end

    slot_tracker #(
        .FRAME_LEN(NSECT),
        .IDX_W    (IDX_W)
    ) u_slots (
        .clk     (clk),
        .rst     (rst),
        .cap_idx (samp_idx),
        .hand_idx(xfer_idx)
    );

    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $countones(samp_stb) == 1) else $error("capture strobe count not one"); // R5
    AST_ONE_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        $countones(xfer_stb) == 1) else $error("handoff strobe count not one"); // R5
    AST_CAP_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
        samp_stb[samp_idx]) else $error("samp_idx does not point at capturing section"); // R6
    AST_HAND_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
        xfer_stb[xfer_idx]) else $error("xfer_idx does not point at handoff section"); // R7
    AST_IDX_GAP: assert property (@(posedge clk) disable iff (rst)
        IDX_W'(samp_idx - xfer_idx) == IDX_GAP) else $error("index gap wrong"); // R7
    AST_STAGGER: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> samp_stb == {$past(samp_stb[NSECT-2:0]), $past(samp_stb[NSECT-1])})
        else $error("capture pattern not staggered by one clock"); // R4

endmodule

// File: tb/stagger_seq_bench.sv
`timescale 1ns/1ps
module stagger_seq_bench;
    localparam int N = 16;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] zref_stb, azero_stb, acal_stb, samp_stb, sar_stb, xfer_stb;
    logic [W-1:0] samp_idx, xfer_idx;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    stagger_seq u_stagger_seq (
        .clk(clk), .rst(rst),
        .zref_stb(zref_stb), .azero_stb(azero_stb), .acal_stb(acal_stb),
        .samp_stb(samp_stb), .sar_stb(sar_stb), .xfer_stb(xfer_stb),
        .samp_idx(samp_idx), .xfer_idx(xfer_idx)
    );

    // Step code from frame position: 0 zref,1 azero,2 acal,3 capture,4 sar,5 transfer
    function automatic int step_code(input int pos);
        if (pos < 4)   return pos;
        if (pos < 15)  return 4;
        return 5;
    endfunction

    function automatic logic [N-1:0] exp_vec(input int n, input int code);
        logic [N-1:0] v;
        for (int k = 0; k < N; k++)
            v[k] = (step_code(((n % N) + N - k) % N) == code);
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input int n, input string tag);
        check({tag, " zref_stb"},  32'(zref_stb),  32'(exp_vec(n, 0)));
        check({tag, " azero_stb"}, 32'(azero_stb), 32'(exp_vec(n, 1)));
        check({tag, " acal_stb"},  32'(acal_stb),  32'(exp_vec(n, 2)));
        check({tag, " samp_stb"},  32'(samp_stb),  32'(exp_vec(n, 3)));
        check({tag, " sar_stb"},   32'(sar_stb),   32'(exp_vec(n, 4)));
        check({tag, " xfer_stb"},  32'(xfer_stb),  32'(exp_vec(n, 5)));
        check("R6 samp_idx", 32'(samp_idx), 32'(((n % N) + N - 3) % N));
        check("R7 xfer_idx", 32'(xfer_idx), 32'(((n % N) + N - 15) % N));
        check("R7 idx gap",  32'(W'(samp_idx - xfer_idx)), 32'd12);
        check("R5 one sampler",    32'($countones(samp_stb)), 32'd1);
        check("R5 one transferer", 32'($countones(xfer_stb)), 32'd1);
        for (int k = 0; k < N; k++)
            check("R8 one step per section",
                  32'(zref_stb[k] + azero_stb[k] + acal_stb[k] + samp_stb[k] + sar_stb[k] + xfer_stb[k]),
                  32'd1);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int           n;
        int           hold;
        logic [N-1:0] prev_samp, prev_xfer;
        bit           prev_ok;
        void'($urandom(32'd20240611));
        n = 0;
        hold = 0;
        prev_ok = 1'b0;
        prev_samp = '0;
        prev_xfer = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(0, "R1");
        check("R1 section13 samples", 32'(samp_stb[13]), 32'd1);
        check("R1 section1 transfers", 32'(xfer_stb[1]), 32'd1);
        rst = 1'b0;
        for (int step = 0; step < 4000; step++) begin
            @(posedge clk);
            if (rst) n = 0; else n = n + 1;
            @(negedge clk);
            if (n == 0) check_all(0, "R9");
            else if (n < N) check_all(n, "R2");
            else check_all(n, "R3");
            if (n >= 1 && n <= 16)
                check("R3 period 16", 32'(samp_stb), 32'(exp_vec(n + 16, 3)));
            if (prev_ok && n != 0) begin
                check("R4 stagger samp", 32'(samp_stb), 32'({prev_samp[N-2:0], prev_samp[N-1]}));
                check("R4 stagger xfer", 32'(xfer_stb), 32'({prev_xfer[N-2:0], prev_xfer[N-1]}));
            end
            prev_samp = samp_stb;
            prev_xfer = xfer_stb;
            prev_ok   = 1'b1;
            // Random mid-run reset pulses, plus one directed pulse at a wrap point
            if (hold > 0) begin
                hold--;
                rst = (hold > 0);
            end else if (step == 47 || ($urandom % 100) < 2) begin
                hold = 1 + int'($urandom % 3);
                rst = 1'b1;
            end else begin
                rst = 1'b0;
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule